// File: doc/BRIEF.md
# SIMD Horizontal Widening Add/Subtract Unit

This datapath combines neighbouring elements of two 128-bit source vectors into a vector of wider results. Each result lane is twice the width of a source element. It is built from the odd-numbered element of source A and the even-numbered element of source B that sit inside that lane's slot. Both elements are widened to the result width, by sign or zero extension, and are then added, or B is subtracted from A.

Three control inputs set the operation. A 2-bit width code picks one of four element sizes, from bytes up to doublewords. A flag picks the extension type, and a second flag picks add or subtract. At the widest size the unit produces one 128-bit result from the upper doubleword of A and the lower doubleword of B.

An optional output register, enabled by a parameter, captures the result when `valid_i` is high. The register then presents the result and `valid_o` one cycle later. The unit does not saturate and raises no flags.

Top module: `simd_hwiden_addsub`

## Requirements
- R1: Result lane i (width RW) is computed from source A element 2*i+1 and source B element 2*i (width RW/2, element 0 at bit 0), with A as the left operand.
- R2: `size_i` selects the element width: 0 = 8 to 16 bits (8 lanes), 1 = 16 to 32 (4 lanes), 2 = 32 to 64 (2 lanes), 3 = 64 to 128 (1 lane).
- R3: With `sub_i` = 0 each lane is the sum of the two widened elements.
- R4: With `sub_i` = 1 each lane is the A element minus the B element.
- R5: With `signed_i` = 1 both elements are sign-extended to the result width before the operation.
- R6: With `signed_i` = 0 both elements are zero-extended to the result width.
- R7: With `size_i` = 3 the result is `src_a_i[127:64]` combined with `src_b_i[63:0]` using full 128-bit arithmetic.
- R8: Each lane keeps only its low RW bits. Unsigned underflow wraps, and no saturation is applied.
- R9: With the output register enabled, `result_o` and `valid_o` appear one clock after the edge that samples `valid_i` high, and `valid_o` equals `valid_i` delayed by one clock.
- R10: With the output register enabled, `result_o` holds its value after an edge where `valid_i` is low.
- R11: While `rst_ni` is low, `valid_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are valid |
| size_i | input | 2 | Element width code |
| signed_i | input | 1 | 1 = sign extension, 0 = zero extension |
| sub_i | input | 1 | 1 = subtract (A minus B), 0 = add |
| src_a_i | input | 128 | Source vector A (supplies the odd elements) |
| src_b_i | input | 128 | Source vector B (supplies the even elements) |
| valid_o | output | 1 | Result valid |
| result_o | output | 128 | Packed widened results |

## Verification
The bench builds the unit with its defaults: a 128-bit vector and the output register enabled.

The 128-bit width lets all four size codes be reached, including the single-lane 128-bit case. Enabling the register brings the one-cycle latency, the hold behaviour on idle cycles and the reset values within reach.

Every size, sign and operation combination is run over operands built from the most negative element, all-ones, zero and mixed patterns. Directed cases pin down wraparound and widest-mode results with literal values.

// File: rtl/hwas_pkg.sv
package hwas_pkg;
  typedef enum logic [1:0] {
    SZ_B2H = 2'd0,
    SZ_H2W = 2'd1,
    SZ_W2D = 2'd2,
    SZ_D2Q = 2'd3
  } size_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned MIN_RES_W = 16;
endpackage

// File: rtl/hwas_lane.sv
module hwas_lane #(
  parameter int unsigned ELEM_W = 8,
  localparam int unsigned RES_W = 2 * ELEM_W
) (
  input  logic [ELEM_W-1:0] a_el_i,
  input  logic [ELEM_W-1:0] b_el_i,
  input  logic              signed_i,
  input  logic              sub_i,
  output logic [RES_W-1:0]  res_o
);
  logic [RES_W-1:0] a_x, b_x;

  assign a_x   = {{ELEM_W{signed_i & a_el_i[ELEM_W-1]}}, a_el_i};
  assign b_x   = {{ELEM_W{signed_i & b_el_i[ELEM_W-1]}}, b_el_i};
  assign res_o = sub_i ? (a_x - b_x) : (a_x + b_x);
endmodule

// File: rtl/hwas_lane_group.sv
module hwas_lane_group #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned RES_W = 16,
  localparam int unsigned ELEM_W = RES_W / 2,
  localparam int unsigned LANES  = VEC_W / RES_W
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             signed_i,
  input  logic             sub_i,
  output logic [VEC_W-1:0] res_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    hwas_lane #(.ELEM_W(ELEM_W)) u_lane (
      .a_el_i  (a_i[(2*i+1)*ELEM_W +: ELEM_W]),
      .b_el_i  (b_i[(2*i)*ELEM_W +: ELEM_W]),
      .signed_i(signed_i),
      .sub_i   (sub_i),
      .res_o   (res_o[i*RES_W +: RES_W])
    );
  end
endmodule

// File: rtl/hwas_out_stage.sv
module hwas_out_stage #(
  parameter int unsigned W  = 128,
  parameter bit          EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  if (EN) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        data_o  <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) data_o <= data_i;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o    = valid_i;
    assign data_o     = data_i;
  end
endmodule

// File: rtl/simd_hwiden_addsub.sv
module simd_hwiden_addsub #(
  parameter int unsigned VEC_W   = 128,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       size_i,
  input  logic             signed_i,
  input  logic             sub_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] result_o
);
  import hwas_pkg::*;

  logic [VEC_W-1:0] grp_res [NUM_SIZES];
  logic [VEC_W-1:0] res_d;
  size_e            size_sel;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    hwas_lane_group #(.VEC_W(VEC_W), .RES_W(MIN_RES_W << k)) u_grp (
      .a_i     (src_a_i),
      .b_i     (src_b_i),
      .signed_i(signed_i),
      .sub_i   (sub_i),
      .res_o   (grp_res[k])
    );
  end

  assign size_sel = size_e'(size_i);

  always_comb begin
    unique case (size_sel)
      SZ_B2H:  res_d = grp_res[0];
      SZ_H2W:  res_d = grp_res[1];
      SZ_W2D:  res_d = grp_res[2];
      default: res_d = grp_res[3];
    endcase
  end

  hwas_out_stage #(.W(VEC_W), .EN(OUT_REG)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (res_d),
    .valid_o(valid_o),
    .data_o (result_o)
  );
endmodule

// File: rtl/hwas_checker.sv
module hwas_checker #(
  parameter int unsigned VEC_W   = 128,
  parameter bit          OUT_REG = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       size_i,
  input logic             signed_i,
  input logic             sub_i,
  input logic [VEC_W-1:0] src_a_i,
  input logic [VEC_W-1:0] src_b_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] result_o
);
  localparam int unsigned H = VEC_W / 2;

  logic [VEC_W-1:0] qa, qb;
  assign qa = {{H{signed_i & src_a_i[VEC_W-1]}}, src_a_i[VEC_W-1:H]};
  assign qb = {{H{signed_i & src_b_i[H-1]}}, src_b_i[H-1:0]};

  if (OUT_REG) begin : g_chk
    // R11
    always_comb begin
      if (!rst_ni) begin
        a_reset_zero_r11: assert (!valid_o && result_o == '0);
      end
    end

    p_valid_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);

    p_valid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);

    p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(result_o));

    p_pair_byte_add_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && size_i == 2'd0 && !sub_i && !signed_i) |=>
        result_o[15:0] == ($past({8'h00, src_a_i[15:8]}) + $past({8'h00, src_b_i[7:0]})));

    p_quad_sub_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && size_i == 2'd3 && sub_i) |=> result_o == ($past(qa) - $past(qb)));

    p_quad_add_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && size_i == 2'd3 && !sub_i) |=> result_o == ($past(qa) + $past(qb)));
  end
endmodule

bind simd_hwiden_addsub hwas_checker #(.VEC_W(VEC_W), .OUT_REG(OUT_REG)) u_hwas_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .size_i  (size_i),
  .signed_i(signed_i),
  .sub_i   (sub_i),
  .src_a_i (src_a_i),
  .src_b_i (src_b_i),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/tb_simd_hwiden_addsub.sv
`timescale 1ns/1ps
module tb_simd_hwiden_addsub;
  localparam int NV = 6;
  localparam logic [127:0] TBL_A [NV] = '{
    128'h0,
    {128{1'b1}},
    {16{8'h80}},
    128'h8000_0000_0000_0000_8000_0000_0000_0000,
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    {4{32'h7FFF_8000}}
  };
  localparam logic [127:0] TBL_B [NV] = '{
    {128{1'b1}},
    {128{1'b1}},
    {16{8'h7F}},
    128'h8000_0000_0000_0000_8000_0000_0000_0000,
    128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0,
    {4{32'h8000_7FFF}}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   size_i = '0;
  logic         signed_i = 1'b0;
  logic         sub_i = 1'b0;
  logic [127:0] a_i = '0;
  logic [127:0] b_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simd_hwiden_addsub dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .size_i(size_i),
    .signed_i(signed_i), .sub_i(sub_i), .src_a_i(a_i), .src_b_i(b_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                         int sz, bit sg, bit sb);
    logic [127:0] out = '0;
    int e = 8 << sz;
    int r = 2 * e;
    for (int i = 0; i < 128 / r; i++) begin
      logic [127:0] x = '0;
      logic [127:0] y = '0;
      logic [127:0] s;
      for (int k = 0; k < e; k++) begin
        x[k] = a[(2*i+1)*e + k];
        y[k] = b[2*i*e + k];
      end
      for (int k = e; k < r; k++) begin
        x[k] = sg ? x[e-1] : 1'b0;
        y[k] = sg ? y[e-1] : 1'b0;
      end
      s = sb ? x - y : x + y;
      for (int k = 0; k < r; k++) out[i*r + k] = s[k];
    end
    return out;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [127:0] a, logic [127:0] b, int sz, bit sg, bit sb);
    @(negedge clk);
    a_i = a; b_i = b; size_i = 2'(sz); signed_i = sg; sub_i = sb; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    chk("R11 valid_o in reset", 128'(valid_o), 128'h0);
    chk("R11 result_o in reset", result_o, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 R8 sweep
    for (int v = 0; v < NV; v++)
      for (int sz = 0; sz < 4; sz++)
        for (int sg = 0; sg < 2; sg++)
          for (int sb = 0; sb < 2; sb++) begin
            run_op(TBL_A[v], TBL_B[v], sz, sg[0], sb[0]);
            chk($sformatf("R1 R2 %s %s %s R8 vec%0d size%0d", sb ? "R4" : "R3",
                          sg ? "R5" : "R6", sz == 3 ? "R7" : "lanes", v, sz),
                result_o, model(TBL_A[v], TBL_B[v], sz, sg[0], sb[0]));
          end

    // R9 latency: not visible before the edge, visible after
    @(negedge clk);
    a_i = TBL_A[4]; b_i = TBL_B[4]; size_i = 2'd1; signed_i = 1'b0; sub_i = 1'b0;
    valid_i = 1'b1;
    #1 chk("R9 valid_o before edge", 128'(valid_o), 128'h0);
    @(negedge clk);
    valid_i = 1'b0;
    chk("R9 valid_o after edge", 128'(valid_o), 128'h1);
    chk("R9 result after edge", result_o, model(TBL_A[4], TBL_B[4], 1, 1'b0, 1'b0));
    held = result_o;

    // R10 hold while idle with changed operands
    a_i = ~a_i; b_i = 128'h0; size_i = 2'd3; sub_i = 1'b1;
    @(negedge clk);
    chk("R9 valid_o drops", 128'(valid_o), 128'h0);
    chk("R10 result held", result_o, held);

    // R8 unsigned byte wrap: 0 - 0xFF = 0xFF01
    run_op(128'h0, {128{1'b1}}, 0, 1'b0, 1'b1);
    chk("R8 R6 byte wrap", result_o, {8{16'hFF01}});
    // R5 signed byte: 0 - (-1) = 1
    run_op(128'h0, {128{1'b1}}, 0, 1'b1, 1'b1);
    chk("R5 signed byte sub", result_o, {8{16'h0001}});
    // R7 R5 quad: min + min
    run_op(128'h8000_0000_0000_0000_0000_0000_0000_0000,
           128'h0000_0000_0000_0000_8000_0000_0000_0000, 3, 1'b1, 1'b0);
    chk("R7 R5 quad signed add", result_o, 128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000);
    // R7 R6 quad: all-ones + all-ones unsigned
    run_op({128{1'b1}}, {128{1'b1}}, 3, 1'b0, 1'b0);
    chk("R7 R6 quad unsigned add", result_o, 128'h1_FFFF_FFFF_FFFF_FFFE);
    // R1 pairing: only odd A, even B elements contribute
    run_op(128'h0000_0000_0000_0000_0000_0000_0000_0500,
           128'h0000_0000_0000_0000_0000_0000_0000_0003, 0, 1'b0, 1'b1);
    chk("R1 R4 pairing", result_o, 128'h0002);
    run_op(128'h0000_0000_0000_0000_0000_0000_0000_0005,
           128'h0000_0000_0000_0000_0000_0000_0000_0300, 0, 1'b0, 1'b0);
    chk("R1 R3 unpaired ignored", result_o, 128'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule